// File: doc/BRIEF.md
# Programmable Waveform Bus Master

This block drives an external parallel bus with a waveform that software loads as a small table of vectors. Every vector sets six control outputs and then does one of two things. A timed vector holds for a programmed number of cycles. A branch vector tests the ready inputs and picks one of two next vectors. On the cycle a vector ends, it can also step a FIFO pointer and bump a 9-bit bus address.

A 32-bit transfer counter is loaded before a run and counts down once for every FIFO step. When it reaches zero, the engine returns to idle, the control outputs take their idle value and a done flag is raised. While the FIFO cannot supply or accept a word, any vector that wants to step it is held in place. The run is therefore throttled rather than overrunning the FIFO. Configuration arrives over a simple register write port that is ignored while a run is active.

Top module: `wfm_master`

## Requirements
- R1: After reset, `ctl_out` equals the `CTL_IDLE` parameter. `adr_out`, `fifo_ptr`, `tc_out`, `busy`, `done` and `fifo_step` are all zero, and every vector slot holds zero.
- R2: A write with `cfg_we` high and `busy` low takes effect at the next clock edge. `cfg_addr` 0 to 7 loads vector slot 0 to 7. Address 8 loads the 32-bit transfer count, which is visible on `tc_out`. Address 9 loads the bus address from bits 8:0, which is visible on `adr_out`. Address 10 sets the bus width from bit 0 (1 means 16-bit).
- R3: The vector word is laid out as follows:
  - bits 5:0: control output value
  - bit 6: FIFO step
  - bit 7: address increment
  - bit 8: branch mode
  - bits 11:9: ready select A
  - bits 14:12: ready select B
  - bits 16:15: condition operator (0 = A, 1 = A AND B, 2 = A OR B, 3 = A XOR B)
  - bits 19:17: next/true index
  - bits 22:20: false index
  - bits 31:23: hold count

  A ready select of 0 to 5 picks that `rdy_in` bit, and 6 or 7 reads as constant 1.
- R4: A timed vector (bit 8 clear) drives its control value for hold count + 1 cycles and then moves to its next index.
- R5: A branch vector lasts one cycle per evaluation. It moves to the true index when its condition on `rdy_in` holds in that cycle, and to the false index otherwise.
- R6: A vector with FIFO step set cannot finish while `fifo_ok` is low. It keeps its control value, `fifo_step` stays low and `tc_out` is unchanged. `fifo_step` is high exactly in the cycle such a vector finishes.
- R7: Each FIFO step lowers `tc_out` by one. The step that takes it from 1 to 0 ends the run: on the next cycle `busy` is low, `ctl_out` is `CTL_IDLE` and `done` is high.
- R8: A `start` pulse while idle with a transfer count of zero starts nothing. `done` is high on the next cycle and `busy` stays low.
- R9: The bus address increments by one when a vector with address increment set finishes, wrapping from 511 to 0.
- R10: `fifo_ptr` is cleared when a run starts. It advances by 1 per FIFO step in 8-bit mode and by 2 in 16-bit mode, modulo 512.
- R11: A `start` pulse while idle with a nonzero count raises `busy`, clears `done` and begins at vector 0 on the next cycle.
- R12: Configuration writes during a run change neither the vectors nor the count nor the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | Begin a run |
| rdy_in | input | 6 | Ready inputs tested by branch vectors |
| fifo_ok | input | 1 | FIFO can supply/accept a word |
| ctl_out | output | 6 | Control outputs |
| adr_out | output | 9 | Bus address |
| fifo_step | output | 1 | FIFO advance pulse |
| fifo_ptr | output | 9 | FIFO byte pointer |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |
| tc_out | output | 32 | Remaining transfer count |

## Verification
The bench instantiates the block with `CTL_IDLE` set to 6'b101010. This keeps the idle level apart from both zero and every vector value it loads, so a return to idle is visible on its own. The package widths are used unchanged. The 9-bit address and FIFO pointer therefore reach their wrap points within a few hundred cycles. A count of 257 in 16-bit mode takes the pointer past the wrap. The 32-bit counter is loaded with its all-ones value to show the full width decrementing.

// File: rtl/wfm_pkg.sv
package wfm_pkg;
    localparam int CTL_W  = 6;
    localparam int RDY_W  = 6;
    localparam int ADR_W  = 9;
    localparam int TC_W   = 32;
    localparam int N_VEC  = 8;
    localparam int IDX_W  = $clog2(N_VEC);
    localparam int SEL_W  = 3;
    localparam int WAIT_W = 9;
    localparam int CFG_AW = 4;
    localparam int CFG_DW = 32;

    localparam logic [CFG_AW-1:0] REG_COUNT = CFG_AW'(8);
    localparam logic [CFG_AW-1:0] REG_ADDR  = CFG_AW'(9);
    localparam logic [CFG_AW-1:0] REG_MODE  = CFG_AW'(10);

    typedef enum logic [1:0] {
        COND_A   = 2'd0,
        COND_AND = 2'd1,
        COND_OR  = 2'd2,
        COND_XOR = 2'd3
    } cond_op_e;

    typedef struct packed {
        logic [WAIT_W-1:0] hold;
        logic [IDX_W-1:0]  nxt_f;
        logic [IDX_W-1:0]  nxt_t;
        cond_op_e          op;
        logic [SEL_W-1:0]  sel_b;
        logic [SEL_W-1:0]  sel_a;
        logic              branch;
        logic              addr_inc;
        logic              fifo_adv;
        logic [CTL_W-1:0]  ctl;
    } vec_t;

    typedef struct packed {
        logic [TC_W-1:0]  tc;
        logic [ADR_W-1:0] adr;
        logic [ADR_W-1:0] ptr;
        logic             wide;
        logic             done;
    } xfer_t;

    typedef struct packed {
        logic              run;
        logic [IDX_W-1:0]  idx;
        logic [WAIT_W-1:0] tmr;
    } seq_t;
endpackage

// File: rtl/wfm_vec_table.sv
module wfm_vec_table
    import wfm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  vec_t             wr_vec,
    input  logic [IDX_W-1:0] rd_idx,
    output vec_t             rd_vec
);
    vec_t [N_VEC-1:0] ent_d;
    vec_t [N_VEC-1:0] ent_q;

    for (genvar g = 0; g < N_VEC; g++) begin : g_slot
        assign ent_d[g] = (wr_en && (wr_idx == IDX_W'(g))) ? wr_vec : ent_q[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign rd_vec = ent_q[rd_idx];
endmodule

// File: rtl/wfm_cond_eval.sv
module wfm_cond_eval
    import wfm_pkg::*;
(
    input  logic [RDY_W-1:0] rdy,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    input  cond_op_e         op,
    output logic             cond
);
    logic pick_a;
    logic pick_b;

    // selects beyond the ready inputs read as constant true
    always_comb begin
        pick_a = 1'b1;
        pick_b = 1'b1;
        for (int i = 0; i < RDY_W; i++) begin
            if (sel_a == SEL_W'(i)) pick_a = rdy[i];
            if (sel_b == SEL_W'(i)) pick_b = rdy[i];
        end
    end

    always_comb begin
        unique case (op)
            COND_A:   cond = pick_a;
            COND_AND: cond = pick_a & pick_b;
            COND_OR:  cond = pick_a | pick_b;
            COND_XOR: cond = pick_a ^ pick_b;
            default:  cond = pick_a;
        endcase
    end
endmodule

// File: rtl/wfm_xfer_regs.sv
module wfm_xfer_regs
    import wfm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_count,
    input  logic              ld_addr,
    input  logic              ld_mode,
    input  logic [CFG_DW-1:0] wdata,
    input  logic              clr_ptr,
    input  logic              step,
    input  logic              ainc,
    input  logic              set_done,
    input  logic              clr_done,
    output logic [TC_W-1:0]   tc,
    output logic [ADR_W-1:0]  adr,
    output logic [ADR_W-1:0]  ptr,
    output logic              done,
    output logic              tc_one,
    output logic              tc_zero
);
    xfer_t x_d;
    xfer_t x_q;
    logic [ADR_W-1:0] ptr_inc;

    assign ptr_inc = x_q.wide ? ADR_W'(2) : ADR_W'(1);

    always_comb begin
        x_d = x_q;
        if (ld_count) x_d.tc   = wdata[TC_W-1:0];
        if (ld_addr)  x_d.adr  = wdata[ADR_W-1:0];
        if (ld_mode)  x_d.wide = wdata[0];
        if (clr_ptr)  x_d.ptr  = '0;
        if (step) begin
            x_d.tc  = x_q.tc - TC_W'(1);
            x_d.ptr = x_q.ptr + ptr_inc;
        end
        if (ainc)     x_d.adr  = x_q.adr + ADR_W'(1);
        if (set_done)      x_d.done = 1'b1;
        else if (clr_done) x_d.done = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign tc      = x_q.tc;
    assign adr     = x_q.adr;
    assign ptr     = x_q.ptr;
    assign done    = x_q.done;
    assign tc_one  = (x_q.tc == TC_W'(1));
    assign tc_zero = (x_q.tc == '0);

    assert_tc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (tc == $past(tc) - TC_W'(1)));

    assert_adr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ainc && !ld_addr) |=> (adr == ADR_W'($past(adr) + ADR_W'(1))));
endmodule

// File: rtl/wfm_master.sv
module wfm_master
    import wfm_pkg::*;
#(
    parameter logic [CTL_W-1:0] CTL_IDLE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              start,
    input  logic [RDY_W-1:0]  rdy_in,
    input  logic              fifo_ok,
    output logic [CTL_W-1:0]  ctl_out,
    output logic [ADR_W-1:0]  adr_out,
    output logic              fifo_step,
    output logic [ADR_W-1:0]  fifo_ptr,
    output logic              busy,
    output logic              done,
    output logic [TC_W-1:0]   tc_out
);
    seq_t s_d;
    seq_t s_q;

    vec_t vec;
    logic cond;
    logic cfg_ok, wr_vec_en;
    logic tc_one, tc_zero;
    logic hold_done, vec_end, adv_ok, complete;
    logic do_ainc, last_xfer;
    logic go, go_run, go_zero;
    logic [IDX_W-1:0] nxt_idx;

    assign cfg_ok    = cfg_we & ~s_q.run;
    assign wr_vec_en = cfg_ok & (cfg_addr < CFG_AW'(N_VEC));

    wfm_vec_table u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_vec_en),
        .wr_idx (cfg_addr[IDX_W-1:0]),
        .wr_vec (vec_t'(cfg_wdata)),
        .rd_idx (s_q.idx),
        .rd_vec (vec)
    );

    wfm_cond_eval u_cond (
        .rdy   (rdy_in),
        .sel_a (vec.sel_a),
        .sel_b (vec.sel_b),
        .op    (vec.op),
        .cond  (cond)
    );

    always_comb begin
        hold_done = (s_q.tmr == vec.hold);
        vec_end   = vec.branch | hold_done;
        adv_ok    = ~vec.fifo_adv | fifo_ok;
        complete  = s_q.run & vec_end & adv_ok;
        nxt_idx   = (vec.branch && !cond) ? vec.nxt_f : vec.nxt_t;
        fifo_step = complete & vec.fifo_adv;
        do_ainc   = complete & vec.addr_inc;
        last_xfer = fifo_step & tc_one;
        go        = start & ~s_q.run;
        go_run    = go & ~tc_zero;
        go_zero   = go & tc_zero;
    end

    always_comb begin
        s_d = s_q;
        if (go_run) begin
            s_d.run = 1'b1;
            s_d.idx = '0;
            s_d.tmr = '0;
        end else if (s_q.run) begin
            if (last_xfer) begin
                s_d.run = 1'b0;
                s_d.idx = '0;
                s_d.tmr = '0;
            end else if (complete) begin
                s_d.idx = nxt_idx;
                s_d.tmr = '0;
            end else if (!vec.branch && !hold_done) begin
                s_d.tmr = s_q.tmr + WAIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    wfm_xfer_regs u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_count (cfg_ok & (cfg_addr == REG_COUNT)),
        .ld_addr  (cfg_ok & (cfg_addr == REG_ADDR)),
        .ld_mode  (cfg_ok & (cfg_addr == REG_MODE)),
        .wdata    (cfg_wdata),
        .clr_ptr  (go_run),
        .step     (fifo_step),
        .ainc     (do_ainc),
        .set_done (last_xfer | go_zero),
        .clr_done (go_run),
        .tc       (tc_out),
        .adr      (adr_out),
        .ptr      (fifo_ptr),
        .done     (done),
        .tc_one   (tc_one),
        .tc_zero  (tc_zero)
    );

    assign ctl_out = s_q.run ? vec.ctl : CTL_IDLE;
    assign busy    = s_q.run;

    assert_step_needs_fifo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_step |-> fifo_ok);

    assert_tc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fifo_step) |=> $stable(tc_out));

    assert_done_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (tc_out == '0));

    assert_end_after_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(fifo_step));
endmodule

// File: tb/wfm_master_bench.sv
module wfm_master_bench;
    localparam logic [5:0] IDLE = 6'b101010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic [5:0]  rdy_in = '0;
    logic        fifo_ok = 1'b1;
    logic [5:0]  ctl_out;
    logic [8:0]  adr_out;
    logic        fifo_step;
    logic [8:0]  fifo_ptr;
    logic        busy;
    logic        done;
    logic [31:0] tc_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    wfm_master #(.CTL_IDLE(IDLE)) u_wfm_master (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .rdy_in(rdy_in), .fifo_ok(fifo_ok),
        .ctl_out(ctl_out), .adr_out(adr_out), .fifo_step(fifo_step),
        .fifo_ptr(fifo_ptr), .busy(busy), .done(done), .tc_out(tc_out)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkv(int ctl, int adv, int ainc, int br, int sa,
                                        int sb, int op, int nt, int nf, int hold);
        logic [31:0] v;
        v = '0;
        v[5:0]   = ctl[5:0];
        v[6]     = adv[0];
        v[7]     = ainc[0];
        v[8]     = br[0];
        v[11:9]  = sa[2:0];
        v[14:12] = sb[2:0];
        v[16:15] = op[1:0];
        v[19:17] = nt[2:0];
        v[22:20] = nf[2:0];
        v[31:23] = hold[8:0];
        return v;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[3:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic go;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset();
        chk("R1", "ctl", 32'(ctl_out), 32'(IDLE));
        chk("R1", "adr", 32'(adr_out), 0);
        chk("R1", "ptr", 32'(fifo_ptr), 0);
        chk("R1", "tc", tc_out, 0);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "step", 32'(fifo_step), 0);
    endtask

    // R3 R4 R7 R10: timed vector held 3 cycles, stepping vector 1 cycle, 3 transfers
    task automatic t_timed;
        wr(0, mkv(6'h05, 0, 0, 0, 0, 0, 0, 1, 0, 2));
        wr(1, mkv(6'h0A, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(10, 0);
        wr(8, 3);
        chk("R2", "count readback", tc_out, 3);
        go();
        for (int k = 0; k < 12; k++) begin
            chk("R4", "ctl sequence", 32'(ctl_out), (k % 4 == 3) ? 32'h0A : 32'h05);
            chk("R6", "step pulse", 32'(fifo_step), (k % 4 == 3) ? 1 : 0);
            chk("R7", "count", tc_out, 32'(3 - k / 4));
            @(negedge clk);
        end
        chk("R7", "busy end", 32'(busy), 0);
        chk("R7", "done end", 32'(done), 1);
        chk("R7", "ctl idle", 32'(ctl_out), 32'(IDLE));
        chk("R7", "tc zero", tc_out, 0);
        chk("R10", "ptr 8-bit", 32'(fifo_ptr), 3);
    endtask

    task automatic t_restart;
        wr(8, 1);
        go();
        chk("R11", "done cleared", 32'(done), 0);
        chk("R11", "busy", 32'(busy), 1);
        chk("R11", "starts at vector 0", 32'(ctl_out), 32'h05);
        repeat (4) @(negedge clk);
        chk("R11", "done again", 32'(done), 1);
        chk("R10", "ptr cleared at start", 32'(fifo_ptr), 1);
    endtask

    task automatic t_branch;
        rdy_in = '0;
        wr(0, mkv(6'h11, 0, 0, 1, 2, 4, 1, 1, 0, 0));
        wr(1, mkv(6'h22, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(8, 1);
        go();
        chk("R5", "waits on false", 32'(ctl_out), 32'h11);
        @(negedge clk);
        rdy_in = 6'b000100;
        chk("R5", "still waiting", 32'(ctl_out), 32'h11);
        @(negedge clk);
        chk("R5", "AND needs both", 32'(ctl_out), 32'h11);
        rdy_in = 6'b010100;
        @(negedge clk);
        chk("R5", "true target", 32'(ctl_out), 32'h22);
        chk("R5", "step on target", 32'(fifo_step), 1);
        @(negedge clk);
        chk("R5", "run over", 32'(done), 1);
        // XOR of two set inputs is false -> false target 2
        wr(0, mkv(6'h15, 0, 0, 1, 0, 1, 3, 1, 2, 0));
        wr(2, mkv(6'h33, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(8, 1);
        rdy_in = 6'b000011;
        go();
        chk("R5", "xor vector", 32'(ctl_out), 32'h15);
        @(negedge clk);
        chk("R5", "false target", 32'(ctl_out), 32'h33);
        @(negedge clk);
        chk("R5", "xor run over", 32'(ctl_out), 32'(IDLE));
        rdy_in = '0;
    endtask

    task automatic t_stall;
        logic [8:0] a0;
        a0 = adr_out;
        wr(0, mkv(6'h14, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(8, 5);
        fifo_ok = 1'b0;
        go();
        chk("R6", "held ctl", 32'(ctl_out), 32'h14);
        chk("R6", "no step", 32'(fifo_step), 0);
        wr(8, 9);
        wr(9, 7);
        wr(0, mkv(6'h3F, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        chk("R12", "count kept", tc_out, 5);
        chk("R12", "addr kept", 32'(adr_out), 32'(a0));
        chk("R12", "vector kept", 32'(ctl_out), 32'h14);
        chk("R6", "still stalled", 32'(fifo_step), 0);
        fifo_ok = 1'b1;
        #1;
        chk("R6", "step when ok", 32'(fifo_step), 1);
        for (int k = 0; k < 5; k++) @(negedge clk);
        chk("R7", "five steps", tc_out, 0);
        chk("R7", "stall run done", 32'(done), 1);
    endtask

    task automatic t_zero;
        wr(8, 0);
        go();
        chk("R8", "no run", 32'(busy), 0);
        chk("R8", "done", 32'(done), 1);
        @(negedge clk);
        chk("R8", "ctl idle", 32'(ctl_out), 32'(IDLE));
    endtask

    task automatic t_addr;
        wr(9, 510);
        chk("R2", "addr readback", 32'(adr_out), 510);
        wr(0, mkv(6'h01, 1, 1, 0, 0, 0, 0, 0, 0, 1));
        wr(8, 3);
        go();
        @(negedge clk); @(negedge clk);
        chk("R9", "addr +1", 32'(adr_out), 511);
        @(negedge clk); @(negedge clk);
        chk("R9", "addr wrap", 32'(adr_out), 0);
        @(negedge clk); @(negedge clk);
        chk("R9", "addr after wrap", 32'(adr_out), 1);
        chk("R9", "done", 32'(done), 1);
    endtask

    task automatic t_wide;
        wr(10, 1);
        wr(0, mkv(6'h02, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(8, 257);
        go();
        for (int i = 1; i <= 258; i++) begin
            if (i == 2 || i == 256 || i == 257 || i == 258)
                chk("R10", "ptr 16-bit", 32'(fifo_ptr), 32'((2 * (i - 1)) % 512));
            if (i < 258) @(negedge clk);
        end
        chk("R10", "busy end", 32'(busy), 0);
    endtask

    task automatic t_long;
        do_reset();
        wr(8, 32'hFFFF_FFFF);
        chk("R2", "full count", tc_out, 32'hFFFF_FFFF);
        wr(0, mkv(6'h07, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        go();
        chk("R7", "first", tc_out, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R7", "decrement", tc_out, 32'hFFFF_FFFE);
        do_reset();
    endtask

    initial begin
        t_reset();
        t_timed();
        t_restart();
        t_branch();
        t_stall();
        t_zero();
        t_addr();
        t_wide();
        t_long();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule